// File: doc/BRIEF.md
# Halt Wake-Up and Reset-Cause Controller

This block sits beside a small microcontroller core and owns its low-power halt state. A halt command from the core sets the power-down status flag, clears the time-out flag, restarts the watchdog and gates the system clock. The block then waits for a wake source: an enabled falling edge on one of the eight port pins, an interrupt request, a watchdog overflow, or the external reset pin.

Every exit from halt, and every reset, passes through a fixed settling window of `SETTLE_CYC` cycles (1024 by default) with `busy` high. At the end of the window the block either pulses `resume_next`, so the core runs the instruction after the halt, or waits one more cycle and pulses `take_irq`, so the core enters the interrupt vector. A watchdog overflow while halted gives a warm reset that clears only the program counter and stack pointer. Other resets are cold. The two status flags record the cause of the last reset so that software can read it.

All logic runs on the always-on clock `clk`. That clock also times the settling window. `sys_clk_en` gates the core's clock.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After power-on reset, `flag_to` and `flag_pdf` are 0, `sys_clk_en` is 1, and `busy`, `cold_rst`, `warm_rst`, `resume_next` and `take_irq` are all 0.
- R2: A `halt_cmd` while running sets `flag_pdf` to 1, clears `flag_to` to 0, drops `sys_clk_en` and pulses `wdt_restart` for one cycle, all in the cycle after the command edge.
- R3: A `wdt_clr_cmd` while running clears `flag_pdf` and leaves `flag_to` unchanged.
- R4: While halted, a falling edge on `port_in[i]` wakes the block only when `port_wake_en[i]` is 1. A falling edge on a disabled bit, or a rising edge on any bit, leaves `sys_clk_en` at 0 and `busy` at 0. The pins pass through a two-stage synchronizer, so `busy` rises three cycles after the pin changes.
- R5: After a port wake-up, `busy` stays high for exactly `SETTLE_CYC` cycles. `resume_next` then pulses for one cycle, in the first cycle with `busy` low.
- R6: An interrupt wake-up with `irq_en`=1 and `stack_full`=0 keeps `busy` high for `SETTLE_CYC`+1 cycles. `take_irq` then pulses for one cycle and `resume_next` stays 0.
- R7: An interrupt wake-up with `irq_en`=0, or with `stack_full`=1, behaves as in R5: `resume_next` pulses after `SETTLE_CYC` busy cycles.
- R8: If `irq_req` is already high when halt is entered, it cannot wake the block. Once it has gone low and risen again, it does wake the block.
- R9: A `wdt_timeout` while halted sets `flag_to`=1, keeps `flag_pdf`=1, and holds `warm_rst` high with `cold_rst` low for the `SETTLE_CYC` busy cycles. Neither `resume_next` nor `take_irq` pulses afterwards.
- R10: A `wdt_timeout` while running sets `flag_to` to 1, leaves `flag_pdf` unchanged, and holds `cold_rst` and `busy` for `SETTLE_CYC` cycles.
- R11: `ext_rst` while halted gives `flag_to`=0 and `flag_pdf`=1. `ext_rst` while running leaves both flags unchanged. In both cases `cold_rst` is high while `busy` is high.
- R12: `ext_rst` overrides every other event, including a settling window already in progress. `cold_rst` and `busy` stay high for `SETTLE_CYC` cycles after the last clock edge that sees `ext_rst` high. No resume or interrupt pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock; also times the settling window |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset request, active high |
| halt_cmd | input | 1 | Core executes the halt instruction |
| wdt_clr_cmd | input | 1 | Core executes the clear-watchdog instruction |
| wdt_timeout | input | 1 | Watchdog overflow pulse |
| port_in | input | PORT_W | Asynchronous port pins |
| port_wake_en | input | PORT_W | Per-bit falling-edge wake enable |
| irq_req | input | 1 | Interrupt request flag |
| irq_en | input | 1 | Interrupt enable |
| stack_full | input | 1 | Return stack is full |
| sys_clk_en | output | 1 | System clock gate enable; 0 while halted |
| cold_rst | output | 1 | Full reset of the core |
| warm_rst | output | 1 | Reset of program counter and stack pointer only |
| wdt_restart | output | 1 | One-cycle clear of watchdog counter and prescaler |
| flag_to | output | 1 | Time-out status flag |
| flag_pdf | output | 1 | Power-down status flag |
| busy | output | 1 | Settling window in progress |
| resume_next | output | 1 | One-cycle pulse: continue at the next instruction |
| take_irq | output | 1 | One-cycle pulse: enter the interrupt vector |

## Verification
Interrupt, watchdog and external-reset stimuli act on the first clock edge that samples them, so `busy` is due at the next sample point. A port edge takes three samples because of the synchronizer. The bench measures this latency explicitly and then counts consecutive busy samples, expecting `SETTLE_CYC` (or one more on the interrupt path). It checks the resume or interrupt pulse only in the first sample after busy falls, and checks that it is gone in the sample after that. Flags are read one sample after the command or reset edge. Wake attempts that must be ignored are followed by several idle samples that confirm the clock stays gated and `busy` stays low. All sampling happens on the falling clock edge, and inputs are driven there too.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_GAP    = 3'd3,
        ST_RSET   = 3'd4
    } hwc_state_e;

    typedef enum logic [1:0] {
        WK_NEXT = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WARM = 2'd2
    } wake_kind_e;

    typedef struct packed {
        hwc_state_e st;
        wake_kind_e kind;
        logic       to;
        logic       pdf;
        logic       blk;
        logic       resume;
        logic       take;
        logic       wdtclr;
    } hwc_reg_t;

endpackage

// File: rtl/hwc_port_edge.sv
module hwc_port_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] wake_en,
    output logic         wake
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } edge_reg_t;

    edge_reg_t r_d, r_q;
    logic [W-1:0] fall;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = pins;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: '1, s2: '1, prev: '1};
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall[i] = r_q.prev[i] & ~r_q.s2[i] & wake_en[i];
    end

    assign wake = |fall;

endmodule

// File: rtl/hwc_settle.sv
module hwc_settle #(
    parameter int CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = en && !clr && (cnt_q == LAST);

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter int SETTLE_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst,
    input  logic              halt_cmd,
    input  logic              wdt_clr_cmd,
    input  logic              wdt_timeout,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic              stack_full,
    output logic              sys_clk_en,
    output logic              cold_rst,
    output logic              warm_rst,
    output logic              wdt_restart,
    output logic              flag_to,
    output logic              flag_pdf,
    output logic              busy,
    output logic              resume_next,
    output logic              take_irq
);
    hwc_reg_t r_d, r_q;
    logic     port_wake;
    logic     settle_done;
    logic     in_window;
    logic     tmr_clr;

    hwc_port_edge #(.W(PORT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (port_in),
        .wake_en (port_wake_en),
        .wake    (port_wake)
    );

    assign in_window = (r_q.st == ST_SETTLE) || (r_q.st == ST_RSET);
    assign tmr_clr   = ext_rst || !in_window;

    hwc_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (in_window),
        .done  (settle_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        r_d.take   = 1'b0;
        r_d.wdtclr = 1'b0;
        if (ext_rst) begin
            if (r_q.st == ST_HALT) begin
                r_d.to  = 1'b0;
                r_d.pdf = 1'b1;
            end
            r_d.st = ST_RSET;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (wdt_timeout) begin
                        r_d.to = 1'b1;
                        r_d.st = ST_RSET;
                    end else if (halt_cmd) begin
                        r_d.pdf    = 1'b1;
                        r_d.to     = 1'b0;
                        r_d.wdtclr = 1'b1;
                        r_d.blk    = irq_req;
                        r_d.st     = ST_HALT;
                    end else if (wdt_clr_cmd) begin
                        r_d.pdf = 1'b0;
                    end
                end
                ST_HALT: begin
                    if (!irq_req) begin
                        r_d.blk = 1'b0;
                    end
                    if (wdt_timeout) begin
                        r_d.to   = 1'b1;
                        r_d.kind = WK_WARM;
                        r_d.st   = ST_SETTLE;
                    end else if (irq_req && !r_q.blk) begin
                        r_d.kind = (irq_en && !stack_full) ? WK_IRQ : WK_NEXT;
                        r_d.st   = ST_SETTLE;
                    end else if (port_wake) begin
                        r_d.kind = WK_NEXT;
                        r_d.st   = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        unique case (r_q.kind)
                            WK_NEXT: begin
                                r_d.resume = 1'b1;
                                r_d.st     = ST_RUN;
                            end
                            WK_IRQ:  r_d.st = ST_GAP;
                            default: r_d.st = ST_RUN;
                        endcase
                    end
                end
                ST_GAP: begin
                    r_d.take = 1'b1;
                    r_d.st   = ST_RUN;
                end
                ST_RSET: begin
                    if (settle_done) begin
                        r_d.st = ST_RUN;
                    end
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, kind: WK_NEXT, to: 1'b0, pdf: 1'b0, blk: 1'b0,
                     resume: 1'b0, take: 1'b0, wdtclr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sys_clk_en  = (r_q.st != ST_HALT);
    assign busy        = in_window || (r_q.st == ST_GAP);
    assign cold_rst    = (r_q.st == ST_RSET);
    assign warm_rst    = (r_q.st == ST_SETTLE) && (r_q.kind == WK_WARM);
    assign wdt_restart = r_q.wdtclr;
    assign flag_to     = r_q.to;
    assign flag_pdf    = r_q.pdf;
    assign resume_next = r_q.resume;
    assign take_irq    = r_q.take;

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && !busy && halt_cmd && !ext_rst && !wdt_timeout)
        |=> (!sys_clk_en && flag_pdf && !flag_to && wdt_restart));

    // R3
    wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clk_en && !busy && wdt_clr_cmd && !halt_cmd && !ext_rst && !wdt_timeout)
        |=> (!flag_pdf && $stable(flag_to)));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_next, take_irq}) && ((resume_next || take_irq) -> !busy));

    // R6
    irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(busy) && !$past(resume_next)));

    // R9
    warm_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |-> (flag_to && flag_pdf && !cold_rst && busy));

    // R12
    ext_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (cold_rst && busy && !resume_next && !take_irq));

endmodule

// File: tb/halt_wake_ctrl_test.sv
`timescale 1ns/1ps
module halt_wake_ctrl_test;
    localparam int PW   = 8;
    localparam int SCYC = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 1'b0, halt_cmd = 1'b0, wdt_clr_cmd = 1'b0, wdt_timeout = 1'b0;
    logic [PW-1:0] port_in = '1;
    logic [PW-1:0] port_wake_en = '0;
    logic irq_req = 1'b0, irq_en = 1'b0, stack_full = 1'b0;
    logic sys_clk_en, cold_rst, warm_rst, wdt_restart, flag_to, flag_pdf;
    logic busy, resume_next, take_irq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    halt_wake_ctrl #(.PORT_W(PW), .SETTLE_CYC(SCYC)) uut (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .halt_cmd(halt_cmd),
        .wdt_clr_cmd(wdt_clr_cmd), .wdt_timeout(wdt_timeout), .port_in(port_in),
        .port_wake_en(port_wake_en), .irq_req(irq_req), .irq_en(irq_en),
        .stack_full(stack_full), .sys_clk_en(sys_clk_en), .cold_rst(cold_rst),
        .warm_rst(warm_rst), .wdt_restart(wdt_restart), .flag_to(flag_to),
        .flag_pdf(flag_pdf), .busy(busy), .resume_next(resume_next), .take_irq(take_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Halt from run; ends one sample after the command edge.
    task automatic do_halt(input string req);
        halt_cmd = 1'b1;
        step();
        halt_cmd = 1'b0;
        chk(!sys_clk_en && flag_pdf && !flag_to, req, "halt state clk_en/pdf/to",
            {sys_clk_en, flag_pdf, flag_to}, 3'b010);
    endtask

    // Stimulus was driven just before this task; measure latency, busy length, pulse.
    task automatic measure(input int exp_lat, input int exp_busy, input bit exp_res,
                           input bit exp_take, input string req);
        int lat = 0;
        int n = 0;
        do begin
            step();
            lat++;
        end while (!busy && lat < 8);
        chk(lat == exp_lat, req, "wake latency", lat, exp_lat);
        while (busy && n < SCYC + 8) begin
            n++;
            step();
        end
        chk(n == exp_busy, req, "busy cycles", n, exp_busy);
        chk(resume_next == exp_res && take_irq == exp_take, req, "pulse after window",
            {resume_next, take_irq}, {exp_res, exp_take});
        chk(sys_clk_en && !cold_rst && !warm_rst, req, "running after window",
            {sys_clk_en, cold_rst, warm_rst}, 3'b100);
        step();
        chk(!resume_next && !take_irq, req, "pulse is single cycle",
            {resume_next, take_irq}, 0);
    endtask

    task automatic t_reset();
        chk(!flag_to && !flag_pdf, "R1", "flags after power-on", {flag_to, flag_pdf}, 0);
        chk(sys_clk_en && !busy && !cold_rst && !warm_rst && !resume_next && !take_irq,
            "R1", "outputs after power-on",
            {sys_clk_en, busy, cold_rst, warm_rst, resume_next, take_irq}, 6'b100000);
    endtask

    task automatic t_halt_entry();
        halt_cmd = 1'b1;
        step();
        halt_cmd = 1'b0;
        chk(wdt_restart == 1'b1, "R2", "watchdog restart pulse", wdt_restart, 1);
        chk(!sys_clk_en && flag_pdf && !flag_to, "R2", "halt flags",
            {sys_clk_en, flag_pdf, flag_to}, 3'b010);
        step();
        chk(wdt_restart == 1'b0, "R2", "restart pulse one cycle", wdt_restart, 0);
        chk(!sys_clk_en && !busy, "R2", "stays halted", {sys_clk_en, busy}, 0);
    endtask

    task automatic t_port();
        port_wake_en = 8'h04;
        port_in[0] = 1'b0;          // disabled bit falls
        repeat (6) step();
        chk(!sys_clk_en && !busy, "R4", "disabled bit ignored", {sys_clk_en, busy}, 0);
        port_in[0] = 1'b1;          // rising edge
        repeat (6) step();
        chk(!sys_clk_en && !busy, "R4", "rising edge ignored", {sys_clk_en, busy}, 0);
        port_in[2] = 1'b0;
        measure(3, SCYC, 1'b1, 1'b0, "R5");
        port_in = '1;
        repeat (4) step();
    endtask

    task automatic t_irq_take();
        do_halt("R6");
        irq_en = 1'b1; stack_full = 1'b0; irq_req = 1'b1;
        measure(1, SCYC + 1, 1'b0, 1'b1, "R6");
        irq_req = 1'b0;
        step();
    endtask

    task automatic t_irq_next();
        do_halt("R7");
        irq_en = 1'b0; stack_full = 1'b0; irq_req = 1'b1;
        measure(1, SCYC, 1'b1, 1'b0, "R7");
        irq_req = 1'b0;
        step();
        do_halt("R7");
        irq_en = 1'b1; stack_full = 1'b1; irq_req = 1'b1;
        measure(1, SCYC, 1'b1, 1'b0, "R7");
        irq_req = 1'b0; stack_full = 1'b0;
        step();
    endtask

    task automatic t_irq_blocked();
        irq_en = 1'b1;
        irq_req = 1'b1;
        step();
        do_halt("R8");
        repeat (6) step();
        chk(!sys_clk_en && !busy, "R8", "pending request cannot wake", {sys_clk_en, busy}, 0);
        irq_req = 1'b0;
        step();
        chk(!sys_clk_en && !busy, "R8", "still halted after drop", {sys_clk_en, busy}, 0);
        irq_req = 1'b1;
        measure(1, SCYC + 1, 1'b0, 1'b1, "R8");
        irq_req = 1'b0;
        step();
    endtask

    task automatic t_wdt_halt();
        int n = 0;
        bit warm_ok = 1'b1;
        do_halt("R9");
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk(flag_to && flag_pdf, "R9", "flags after watchdog wake", {flag_to, flag_pdf}, 3);
        while (busy && n < SCYC + 8) begin
            if (!warm_rst || cold_rst) warm_ok = 1'b0;
            n++;
            step();
        end
        chk(warm_ok, "R9", "warm reset held, cold low", warm_ok, 1);
        chk(n == SCYC, "R9", "busy cycles", n, SCYC);
        chk(!resume_next && !take_irq && !warm_rst, "R9", "no pulse after warm reset",
            {resume_next, take_irq, warm_rst}, 0);
        step();
        chk(!resume_next && !take_irq, "R9", "no pulse later", {resume_next, take_irq}, 0);
    endtask

    task automatic t_wdt_clr_and_run();
        logic to_before;
        to_before = flag_to;
        wdt_clr_cmd = 1'b1;
        step();
        wdt_clr_cmd = 1'b0;
        chk(!flag_pdf && flag_to == to_before, "R3", "clear-watchdog flags",
            {flag_to, flag_pdf}, {to_before, 1'b0});
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk(flag_to && !flag_pdf, "R10", "flags after run time-out", {flag_to, flag_pdf}, 2);
        chk(cold_rst && busy, "R10", "cold reset active", {cold_rst, busy}, 3);
        begin
            int n = 1;
            while (busy && n < SCYC + 8) begin
                step();
                if (busy) n++;
            end
            chk(n == SCYC, "R10", "cold window length", n, SCYC);
        end
        chk(!cold_rst && !resume_next && !take_irq, "R10", "no pulse after cold window",
            {cold_rst, resume_next, take_irq}, 0);
    endtask

    // One-cycle ext_rst pulse; counts busy from the sample after its edge.
    task automatic ext_pulse(input string req);
        int n = 0;
        bit cold_ok = 1'b1;
        ext_rst = 1'b1;
        step();
        ext_rst = 1'b0;
        while (busy && n < SCYC + 8) begin
            if (!cold_rst) cold_ok = 1'b0;
            n++;
            step();
        end
        chk(cold_ok, req, "cold reset held while busy", cold_ok, 1);
        chk(n == SCYC, req, "cold window length", n, SCYC);
        chk(!resume_next && !take_irq && !cold_rst && sys_clk_en, req, "quiet after window",
            {resume_next, take_irq, cold_rst, sys_clk_en}, 1);
    endtask

    task automatic t_ext_run();
        logic to_b, pdf_b;
        do_halt("R11");           // flags 0/1 to start from a known pair
        irq_en = 1'b0; irq_req = 1'b1;
        measure(1, SCYC, 1'b1, 1'b0, "R7");
        irq_req = 1'b0;
        wdt_timeout = 1'b1;       // make to=1, pdf=1 before the run-time reset
        step();
        wdt_timeout = 1'b0;
        repeat (SCYC + 2) step();
        to_b = flag_to; pdf_b = flag_pdf;
        chk(to_b && pdf_b, "R10", "pdf unchanged by run time-out", {to_b, pdf_b}, 3);
        ext_pulse("R11");
        chk(flag_to == to_b && flag_pdf == pdf_b, "R11", "run reset keeps flags",
            {flag_to, flag_pdf}, {to_b, pdf_b});
    endtask

    task automatic t_ext_halt();
        wdt_timeout = 1'b1;       // to=1 first so the clear is visible
        step();
        wdt_timeout = 1'b0;
        repeat (SCYC + 2) step();
        wdt_clr_cmd = 1'b1;
        step();
        wdt_clr_cmd = 1'b0;
        do_halt("R11");
        ext_pulse("R11");
        chk(!flag_to && flag_pdf, "R11", "halt reset flags", {flag_to, flag_pdf}, 1);
    endtask

    task automatic t_ext_override();
        do_halt("R12");
        irq_en = 1'b1; irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        repeat (100) step();
        chk(busy && !cold_rst, "R12", "mid-window before reset", {busy, cold_rst}, 2);
        ext_pulse("R12");
        repeat (3) step();
        chk(!take_irq && !resume_next, "R12", "interrupt cancelled", {take_irq, resume_next}, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_halt_entry();
        t_port();
        t_irq_take();
        t_irq_next();
        t_irq_blocked();
        t_wdt_halt();
        t_wdt_clr_and_run();
        t_ext_run();
        t_ext_halt();
        t_ext_override();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule